// File: doc/BRIEF.md
# Slow-Clock Independent Watchdog

This block is a watchdog timer that runs entirely in its own slow clock domain. A 12-bit free-running prescaler divides that clock by a power of two from 1 to 4096. Each prescaler tick decrements an 8-bit counter. Software keeps the system alive by writing a 16-bit key, which reloads the counter to its top value. If the counter passes zero, the block either raises a sticky reset request or sets an interrupt flag and starts a new period. The choice is made by a mode bit.

Two comparators give software early warning. Each one sets its own sticky flag on the tick where the counter steps down onto that comparator's programmed value. Every flag stays set until software writes a 1 to its bit in the clear register. The interrupt request is the OR of the three flags. Counting depends only on the run bit. It continues while the rest of the system is stopped, because the block's clock is the slow oscillator.

Software reaches the block through a one-cycle write strobe with an address and 16 bits of data. There is no read path: the counter value and the flags are brought out as status ports.

Top module: `lsclk_watchdog`

## Requirements
- R1: After reset: `count` is 0xFF, `flags` is 0, `irq` is 0, `rst_req` is 0, and the block is stopped.
- R2: Writing address 0 sets the control fields: bit 0 is run, bit 1 is mode, and bits 6:3 are the prescale select n. Values of n above 12 act as 12. While run is 1, `count` drops by one every 2^n clock cycles. While run is 0, `count` holds.
- R3: A write of 16'h5A3C to address 1 sets `count` to 0xFF and restarts the prescaler, so the next tick comes 2^n cycles later. Any other value written to address 1 has no effect.
- R4: With mode 0, a tick at `count` 0 sets `rst_req` on that edge. `rst_req` then stays at 1 until the asynchronous reset.
- R5: With mode 1, a tick at `count` 0 sets `flags[0]`, reloads `count` to 0xFF, and counting continues.
- R6: A tick that takes `count` down to the value written at address 2 (bits 7:0) sets `flags[1]`. A tick that takes it down to the value written at address 3 sets `flags[2]`.
- R7: Flags are sticky. Writing address 4 clears every flag whose data bit (2:0) is 1. If a flag is set and cleared on the same edge, the set wins.
- R8: `irq` is 1 exactly when any bit of `flags` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 3 | Register address (0 ctrl, 1 key, 2 cmp0, 3 cmp1, 4 clear) |
| wr_data | input | 16 | Write data |
| rst_req | output | 1 | Sticky reset request |
| irq | output | 1 | Interrupt request, OR of flags |
| flags | output | 3 | Flags: underflow, cmp0 hit, cmp1 hit |
| count | output | 8 | Current counter value |

## Verification
The bench walks the counter through the zero crossing in both modes:
- A design that tests for zero one tick too early or too late shifts the reset request or the reload by a whole prescaled period.
- Because the reset request is sticky, a design that let it drop would be visible a few cycles after the crossing.

A slightly wrong key is written to check that it is ignored; a design that compared only part of the key would reload the counter there.

Further directed checks cover the following:
- The prescale select above 12, which must clamp rather than wrap to a short division.
- A flag clear that lands on the same edge as that flag's comparator hit, where a design with the wrong priority would lose the event.

Random writes against a cycle model cover the prescaler restart on a refresh, which a design that left the prescaler running would get wrong by up to one period.

// File: rtl/lsclk_watchdog.sv
module lsclk_watchdog #(
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 12,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] KEY = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rst_req,
  output logic              irq,
  output logic [2:0]        flags,
  output logic [CNT_W-1:0]  count
);
  localparam int SEL_W = $clog2(PRE_W + 1);
  localparam logic [2:0] A_CTRL = 3'd0, A_KEY = 3'd1, A_CMP0 = 3'd2,
                         A_CMP1 = 3'd3, A_CLR = 3'd4;

  logic             run, mode;
  logic [SEL_W-1:0] psel;
  logic [CNT_W-1:0] cmp0, cmp1, cnt;
  logic [PRE_W-1:0] pre;
  logic [2:0]       flg;
  logic             rq;

  wire              refresh = wr_en && wr_addr == A_KEY && wr_data == KEY;
  wire [2:0]        clr     = (wr_en && wr_addr == A_CLR) ? wr_data[2:0] : 3'b000;
  wire [SEL_W-1:0]  n_eff   = (psel > SEL_W'(PRE_W)) ? SEL_W'(PRE_W) : psel;
  wire [PRE_W-1:0]  mask    = ~({PRE_W{1'b1}} << n_eff);
  wire              tick    = run && !refresh && ((pre & mask) == mask);
  wire              under   = tick && cnt == '0;
  wire [CNT_W-1:0]  dec     = cnt - 1'b1;
  wire              hit0    = tick && !under && dec == cmp0;
  wire              hit1    = tick && !under && dec == cmp1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      mode <= 1'b0;
      psel <= '0;
      cmp0 <= '0;
      cmp1 <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          run  <= wr_data[0];
          mode <= wr_data[1];
          psel <= wr_data[3 +: SEL_W];
        end
        A_CMP0: cmp0 <= wr_data[CNT_W-1:0];
        A_CMP1: cmp1 <= wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '1;
      flg <= '0;
      rq  <= 1'b0;
    end else begin
      if (refresh)  pre <= '0;
      else if (run) pre <= pre + 1'b1;
      if (refresh || under) cnt <= '1;
      else if (tick)        cnt <= dec;
      flg <= (flg & ~clr) | {hit1, hit0, under && mode};
      rq  <= rq | (under && !mode);
    end
  end

  assign rst_req = rq;
  assign flags   = flg;
  assign irq     = |flg;
  assign count   = cnt;
endmodule

module lsclk_watchdog_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             mode,
  input logic             tick,
  input logic             refresh,
  input logic [CNT_W-1:0] cnt,
  input logic             irq,
  input logic             rst_req
);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !refresh) |=> $stable(cnt));
  // R3
  refresh_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> cnt == '1);
  // R4
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  // R4
  rst_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == '0 && !mode) |=> rst_req);
  // R5
  wrap_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == '0 && mode) |=> (irq && cnt == '1));
  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick));
endmodule

bind lsclk_watchdog lsclk_watchdog_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .tick(tick),
  .refresh(refresh), .cnt(cnt), .irq(irq), .rst_req(rst_req)
);

// File: tb/test_lsclk_watchdog.sv
`timescale 1ns/1ps
module test_lsclk_watchdog;
  localparam logic [15:0] KEY = 16'h5A3C;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic rst_req, irq;
  logic [2:0] flags;
  logic [7:0] count;
  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  bit m_run, m_mode, m_rq;
  int m_n;
  logic [7:0] m_cmp0, m_cmp1, m_cnt;
  logic [11:0] m_pre;
  logic [2:0] m_flg;

  always #4 clk = ~clk;

  lsclk_watchdog i_lsclk_watchdog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rst_req(rst_req), .irq(irq), .flags(flags), .count(count));

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_run = 0; m_mode = 0; m_rq = 0; m_n = 0;
    m_cmp0 = 0; m_cmp1 = 0; m_cnt = 8'hFF; m_pre = 0; m_flg = 0;
  endtask

  task automatic model_edge(bit we, logic [2:0] a, logic [15:0] d);
    bit refresh = we && a == 3'd1 && d == KEY;
    logic [2:0] clr = (we && a == 3'd4) ? d[2:0] : 3'b000;
    logic [2:0] set = 3'b000;
    logic [11:0] mask = 12'((32'd1 << (m_n > 12 ? 12 : m_n)) - 1);
    if (refresh) begin
      m_cnt = 8'hFF; m_pre = 0;
    end else if (m_run) begin
      if ((m_pre & mask) == mask) begin
        if (m_cnt == 0) begin
          m_cnt = 8'hFF;
          if (m_mode) set[0] = 1; else m_rq = 1;
        end else begin
          m_cnt = m_cnt - 1;
          if (m_cnt == m_cmp0) set[1] = 1;
          if (m_cnt == m_cmp1) set[2] = 1;
        end
      end
      m_pre = m_pre + 1;
    end
    m_flg = (m_flg & ~clr) | set;
    if (we && a == 3'd0) begin m_run = d[0]; m_mode = d[1]; m_n = d[6:3]; end
    if (we && a == 3'd2) m_cmp0 = d[7:0];
    if (we && a == 3'd3) m_cmp1 = d[7:0];
  endtask

  task automatic compare();
    check("R2/R3/R5 count", {8'h0, count}, {8'h0, m_cnt});
    check("R5/R6/R7 flags", {13'h0, flags}, {13'h0, m_flg});
    check("R8 irq", {15'h0, irq}, {15'h0, |m_flg});
    check("R4 rst_req", {15'h0, rst_req}, {15'h0, m_rq});
  endtask

  task automatic cyc(bit we, logic [2:0] a, logic [15:0] d);
    wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    model_edge(we, a, d);
    @(negedge clk);
    wr_en = 0;
    compare();
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) cyc(0, 3'd0, 16'h0);
  endtask

  function automatic logic [15:0] ctrl(bit run, bit mode, int n);
    return 16'({n[3:0], 1'b0, mode, run});
  endfunction

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h1d5e_0a17));
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 count", {8'h0, count}, 16'h00FF);
    check("R1 flags", {13'h0, flags}, 16'h0);
    check("R1 irq", {15'h0, irq}, 16'h0);
    check("R1 rst_req", {15'h0, rst_req}, 16'h0);
    idle(5);
    check("R2 stopped holds", {8'h0, count}, 16'h00FF);

    // interrupt mode, n=0
    cyc(1, 3'd2, 16'h0080);
    cyc(1, 3'd3, 16'h00F0);
    cyc(1, 3'd0, ctrl(1, 1, 0));
    cyc(1, 3'd1, KEY);
    check("R3 refresh", {8'h0, count}, 16'h00FF);
    idle(10);
    check("R2 decrement n=0", {8'h0, count}, 16'h00F5);
    cyc(1, 3'd1, 16'h5A3D);
    check("R3 wrong key ignored", {8'h0, count}, 16'h00F4);
    check("R6 cmp1 hit F0 not yet", {15'h0, flags[2]}, 16'h0);
    idle(4);
    check("R6 cmp1 hit at F0", {15'h0, flags[2]}, 16'h1);
    idle(112);
    check("R6 cmp0 hit at 80", {15'h0, flags[1]}, 16'h1);
    idle(128);
    check("R5 at zero", {8'h0, count}, 16'h0000);
    check("R5 no flag yet", {15'h0, flags[0]}, 16'h0);
    idle(1);
    check("R5 reload", {8'h0, count}, 16'h00FF);
    check("R5 flag set", {15'h0, flags[0]}, 16'h1);
    check("R4 no reset in mode 1", {15'h0, rst_req}, 16'h0);
    cyc(1, 3'd4, 16'h0002);
    check("R7 clear cmp0 only", {13'h0, flags}, 16'h0005);
    check("R8 irq with flags", {15'h0, irq}, 16'h1);
    // same-edge set and clear of flag 2
    cyc(1, 3'd1, KEY);
    idle(14);
    check("R7 setup F1", {8'h0, count}, 16'h00F1);
    cyc(1, 3'd4, 16'h0004);
    check("R7 set wins", {15'h0, flags[2]}, 16'h1);
    cyc(1, 3'd4, 16'h0007);
    check("R7 clear all", {13'h0, flags}, 16'h0);
    check("R8 irq low", {15'h0, irq}, 16'h0);

    // prescale n=2 and refresh restarts prescaler
    cyc(1, 3'd0, ctrl(1, 1, 2));
    cyc(1, 3'd1, KEY);
    idle(3);
    check("R3 prescaler restart", {8'h0, count}, 16'h00FF);
    idle(1);
    check("R2 n=2 first tick", {8'h0, count}, 16'h00FE);

    // clamp n=15 to 12
    cyc(1, 3'd0, ctrl(1, 1, 15));
    cyc(1, 3'd1, KEY);
    idle(4095);
    check("R2 clamp before tick", {8'h0, count}, 16'h00FF);
    idle(1);
    check("R2 clamp tick at 4096", {8'h0, count}, 16'h00FE);

    // random phase
    cyc(1, 3'd0, ctrl(1, 1, 0));
    for (int i = 0; i < 6000; i++) begin
      int r = int'($urandom % 100);
      if (r < 84) cyc(0, 3'd0, 16'h0);
      else if (r < 90) cyc(1, 3'd1, KEY);
      else if (r < 92) cyc(1, 3'd1, 16'($urandom));
      else if (r < 95) cyc(1, 3'd4, 16'($urandom % 8));
      else if (r < 97) cyc(1, 3'd0, ctrl(($urandom % 8) != 0, 1, int'($urandom % 4)));
      else if (r < 99) cyc(1, 3'(2 + $urandom % 2), 16'($urandom % 256));
      else cyc(1, 3'(5 + $urandom % 3), 16'($urandom));
    end

    // reset mode
    do_reset();
    cyc(1, 3'd0, ctrl(1, 0, 0));
    cyc(1, 3'd1, KEY);
    idle(255);
    check("R4 not yet", {15'h0, rst_req}, 16'h0);
    idle(1);
    check("R4 raised", {15'h0, rst_req}, 16'h1);
    check("R4 no irq flag", {15'h0, flags[0]}, 16'h0);
    cyc(1, 3'd1, KEY);
    idle(5);
    check("R4 sticky", {15'h0, rst_req}, 16'h1);
    do_reset();
    check("R1 rst_req cleared", {15'h0, rst_req}, 16'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule